// File: doc/BRIEF.md
# DRAM Rank Region Decoder

This block takes a physical address and finds which DRAM rank holds it. It does this in a memory system of several channels, each with a fixed number of ranks. Software programs one boundary value per rank slot. The values are cumulative within a channel and count in coarse units of 2^GRAIN_SH bytes (64 MiB by default). Software also programs a top-of-memory value in the same units and a flag that restricts decoding to channel 0. A request is an address with a valid strobe. One clock later the block returns a registered result: a hit with the channel, the rank and the flat slot index; an out-of-range indication; or a plain miss.

Channels are laid out one above the other. When the final boundary of the last channel equals top of memory, the layout is stacked. In a stacked layout each later channel's boundaries are absolute addresses, and the channel's first rank begins where the previous channel ends. In a non-stacked layout each later channel's boundaries are offsets, added to the top of the channel below it. The stacked condition is reported on its own output, derived from configuration alone.

The result register is a small state machine with four states. ST_IDLE means no result. ST_HIT means a rank matched. ST_MISS means the address is below top of memory but no rank covers it. ST_OOR means the address is at or above top of memory. Every clock edge moves the machine to one of these states. With no request it goes to ST_IDLE. With a request it goes to ST_OOR when the address is out of range, otherwise to ST_HIT when some rank matches, otherwise to ST_MISS. Any state may follow any state.

Top module: `rank_region_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, rsp_valid, rsp_hit and rsp_oor are 0.
- R2: rsp_valid is 1 exactly in the cycle after a cycle with req_valid high; back-to-back requests produce back-to-back results.
- R3: In channel 0, rank r covers unit addresses u (address shifted right by GRAIN_SH) with B[r-1] <= u < B[r], taking B[-1] = 0; a hit reports rsp_chan 0 and rsp_rank r.
- R4: A boundary value N ends its rank at byte address N*2^GRAIN_SH: the last byte below it belongs to that rank, and the address equal to it belongs to the next non-empty rank.
- R5: In a non-stacked layout, each channel c > 0 has its boundaries added to the absolute top of channel c-1, so channel 1 rank 0 starts at channel 0's last boundary.
- R6: layout_stacked is 1 when cfg_single is 0 and the last boundary of the last channel equals cfg_tom. In that case the later channels' boundaries are absolute, and channel c's rank 0 starts at the top of channel c-1.
- R7: A rank whose upper boundary is not above its lower boundary is empty and never produces a hit.
- R8: When the regions of several non-empty ranks contain the address, the lowest flat slot index wins.
- R9: An address with unit value >= cfg_tom gives rsp_oor 1 and rsp_hit 0, even when a rank region covers it.
- R10: With cfg_single 1, ranks of channels other than 0 never hit and layout_stacked is 0.
- R11: On a hit, rsp_slot equals rsp_rank ORed with rsp_chan times RANKS_PER_CH (channel in the upper bits). Slot s is programmed in cfg_bounds bits [s*BND_W +: BND_W].
- R12: An address below top of memory that no rank covers gives rsp_valid 1 with rsp_hit 0 and rsp_oor 0. Whenever rsp_hit is 0, rsp_slot, rsp_chan and rsp_rank are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bounds | input | NUM_CH*RANKS_PER_CH*BND_W | Cumulative boundary per slot, slot s at bits [s*BND_W +: BND_W] |
| cfg_tom | input | BND_W | Top of memory in grain units |
| cfg_single | input | 1 | Decode channel 0 only |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Physical byte address |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Address falls in a rank |
| rsp_oor | output | 1 | Address at or above top of memory |
| rsp_chan | output | $clog2(NUM_CH) | Channel of the hit |
| rsp_rank | output | $clog2(RANKS_PER_CH) | Rank within the channel |
| rsp_slot | output | $clog2(NUM_CH*RANKS_PER_CH) | Flat slot index |
| layout_stacked | output | 1 | Stacked layout detected |

## Verification
Two things can be true in the same cycle: the top-of-memory range check fails, and a rank window also contains the address. The bench sets up this case on purpose. It programs channel 0 boundaries past a smaller top of memory and sends an address between the two. The result must be rsp_oor with no hit and a zeroed slot. A second collision is between overlapping windows of two channels in a stacked layout. There, a single address matches slot 0 and slot 5 together, and the result must name slot 0.

// File: rtl/rank_region_pkg.sv
package rank_region_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2,
        ST_OOR  = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/rank_layout.sv
module rank_layout #(
    parameter int NUM_CH       = 2,
    parameter int RANKS_PER_CH = 4,
    parameter int BND_W        = 10,
    parameter int CMP_W        = 12
) (
    input  logic [NUM_CH*RANKS_PER_CH*BND_W-1:0] cfg_bounds,
    input  logic [BND_W-1:0]                     cfg_tom,
    input  logic                                 cfg_single,
    output logic [NUM_CH*RANKS_PER_CH*CMP_W-1:0] lo_flat,
    output logic [NUM_CH*RANKS_PER_CH*CMP_W-1:0] hi_flat,
    output logic [NUM_CH*RANKS_PER_CH-1:0]       slot_en,
    output logic                                 stacked
);
    localparam int NSLOT   = NUM_CH * RANKS_PER_CH;
    localparam int LAST_LO = (NSLOT - 1) * BND_W;

    // stacked: final boundary of the last channel reaches top of memory
    assign stacked = (NUM_CH > 1) && !cfg_single &&
                     (cfg_bounds[LAST_LO +: BND_W] == cfg_tom);

    always_comb begin
        logic [CMP_W-1:0] prev_top;
        logic [CMP_W-1:0] base;
        prev_top = '0;
        base     = '0;
        lo_flat  = '0;
        hi_flat  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            base = stacked ? '0 : prev_top;
            for (int r = 0; r < RANKS_PER_CH; r++) begin
                hi_flat[(c*RANKS_PER_CH+r)*CMP_W +: CMP_W] =
                    base + CMP_W'(cfg_bounds[(c*RANKS_PER_CH+r)*BND_W +: BND_W]);
                if (r == 0)
                    lo_flat[(c*RANKS_PER_CH)*CMP_W +: CMP_W] = prev_top;
                else
                    lo_flat[(c*RANKS_PER_CH+r)*CMP_W +: CMP_W] =
                        base + CMP_W'(cfg_bounds[(c*RANKS_PER_CH+r-1)*BND_W +: BND_W]);
            end
            prev_top = base +
                CMP_W'(cfg_bounds[(c*RANKS_PER_CH+RANKS_PER_CH-1)*BND_W +: BND_W]);
        end
    end

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_en
            if (s < RANKS_PER_CH) begin : g_ch0
                assign slot_en[s] = 1'b1;
            end else begin : g_chn
                assign slot_en[s] = !cfg_single;
            end
        end
    endgenerate

endmodule

// File: rtl/rank_window.sv
module rank_window #(
    parameter int CMP_W = 12
) (
    input  logic [CMP_W-1:0] unit_addr,
    input  logic [CMP_W-1:0] lo,
    input  logic [CMP_W-1:0] hi,
    input  logic             enable,
    output logic             match
);
    logic nonempty;
    assign nonempty = hi > lo;
    assign match    = enable && nonempty && (unit_addr >= lo) && (unit_addr < hi);
endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3
) (
    input  logic [NSLOT-1:0]  match_vec,
    output logic              any,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = SLOT_W'(i);
        end
    end
    assign any = |match_vec;
endmodule

// File: rtl/rank_region_decoder.sv
module rank_region_decoder
    import rank_region_pkg::*;
#(
    parameter int NUM_CH       = 2,
    parameter int RANKS_PER_CH = 4,
    parameter int BND_W        = 10,
    parameter int GRAIN_SH     = 26,
    parameter int ADDR_W       = 36
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [NUM_CH*RANKS_PER_CH*BND_W-1:0]       cfg_bounds,
    input  logic [BND_W-1:0]                           cfg_tom,
    input  logic                                       cfg_single,
    input  logic                                       req_valid,
    input  logic [ADDR_W-1:0]                          req_addr,
    output logic                                       rsp_valid,
    output logic                                       rsp_hit,
    output logic                                       rsp_oor,
    output logic [$clog2(NUM_CH)-1:0]                  rsp_chan,
    output logic [$clog2(RANKS_PER_CH)-1:0]            rsp_rank,
    output logic [$clog2(NUM_CH*RANKS_PER_CH)-1:0]     rsp_slot,
    output logic                                       layout_stacked
);
    localparam int NSLOT  = NUM_CH * RANKS_PER_CH;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int RANK_W = $clog2(RANKS_PER_CH);
    localparam int UNIT_W = ADDR_W - GRAIN_SH;
    localparam int WIDE_W = (UNIT_W > BND_W) ? UNIT_W : BND_W;
    localparam int CMP_W  = WIDE_W + $clog2(NUM_CH) + 1;

    logic [CMP_W-1:0]       unit_addr;
    logic [CMP_W-1:0]       tom_ext;
    logic [NSLOT*CMP_W-1:0] lo_flat;
    logic [NSLOT*CMP_W-1:0] hi_flat;
    logic [NSLOT-1:0]       slot_en;
    logic [NSLOT-1:0]       match_vec;
    logic                   pick_any;
    logic [SLOT_W-1:0]      pick_idx;
    logic                   addr_oor;

    rsp_state_e             state_q, state_d;
    logic [SLOT_W-1:0]      slot_q, slot_d;

    assign unit_addr = CMP_W'(req_addr[ADDR_W-1:GRAIN_SH]);
    assign tom_ext   = CMP_W'(cfg_tom);
    assign addr_oor  = unit_addr >= tom_ext;

    rank_layout #(
        .NUM_CH(NUM_CH), .RANKS_PER_CH(RANKS_PER_CH),
        .BND_W(BND_W), .CMP_W(CMP_W)
    ) u_layout (
        .cfg_bounds (cfg_bounds),
        .cfg_tom    (cfg_tom),
        .cfg_single (cfg_single),
        .lo_flat    (lo_flat),
        .hi_flat    (hi_flat),
        .slot_en    (slot_en),
        .stacked    (layout_stacked)
    );

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_win
            rank_window #(.CMP_W(CMP_W)) u_win (
                .unit_addr (unit_addr),
                .lo        (lo_flat[s*CMP_W +: CMP_W]),
                .hi        (hi_flat[s*CMP_W +: CMP_W]),
                .enable    (slot_en[s]),
                .match     (match_vec[s])
            );
        end
    endgenerate

    slot_picker #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_pick (
        .match_vec (match_vec),
        .any       (pick_any),
        .idx       (pick_idx)
    );

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        slot_d  = '0;
        if (req_valid) begin
            if (addr_oor) begin
                state_d = ST_OOR;
            end else if (pick_any) begin
                state_d = ST_HIT;
                slot_d  = pick_idx;
            end else begin
                state_d = ST_MISS;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_oor   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT:  begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            ST_MISS: rsp_valid = 1'b1;
            ST_OOR:  begin rsp_valid = 1'b1; rsp_oor = 1'b1; end
            default: ;
        endcase
    end

    assign rsp_slot = slot_q;
    assign rsp_rank = slot_q[RANK_W-1:0];
    assign rsp_chan = slot_q[SLOT_W-1:RANK_W];

    AST_RSP_AFTER_REQ:  assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid);   // R2
    AST_RSP_DROPS:      assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
    AST_HIT_NOT_OOR:    assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> !rsp_oor);      // R9
    AST_REQ_OOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && addr_oor) |=> (rsp_oor && !rsp_hit)); // R9
    AST_SINGLE_CH0:     assert property (@(posedge clk) disable iff (!rst_n) (rsp_hit && $past(cfg_single)) |-> (rsp_chan == '0)); // R10
    AST_NOHIT_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) !rsp_hit |-> (rsp_slot == '0)); // R12
    AST_PICK_IS_MATCH:  assert property (@(posedge clk) disable iff (!rst_n) pick_any |-> match_vec[pick_idx]); // R8
    AST_PICK_LOWEST:    assert property (@(posedge clk) disable iff (!rst_n)
                            pick_any |-> ((match_vec & ((NSLOT'(1) << pick_idx) - NSLOT'(1))) == '0)); // R8

endmodule

// File: tb/rank_region_decoder_test.sv
`timescale 1ns/1ps
module rank_region_decoder_test;
    localparam int GSH = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] cfg_bounds = '0;
    logic [9:0]  cfg_tom = '0;
    logic        cfg_single = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_oor, layout_stacked;
    logic [0:0]  rsp_chan;
    logic [1:0]  rsp_rank;
    logic [2:0]  rsp_slot;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rank_region_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_bounds(cfg_bounds), .cfg_tom(cfg_tom),
        .cfg_single(cfg_single), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_oor(rsp_oor),
        .rsp_chan(rsp_chan), .rsp_rank(rsp_rank), .rsp_slot(rsp_slot),
        .layout_stacked(layout_stacked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int b0, b1, b2, b3, b4, b5, b6, b7,
                           input int tom, input logic single);
        @(negedge clk);
        cfg_bounds = {10'(b7), 10'(b6), 10'(b5), 10'(b4),
                      10'(b3), 10'(b2), 10'(b1), 10'(b0)};
        cfg_tom    = 10'(tom);
        cfg_single = single;
        #0.1;
    endtask

    // expected slot -1 means no hit
    task automatic check_result(input string tag, input int oor, input int slot);
        chk({tag, " valid"}, int'(rsp_valid), 1);
        chk({tag, " oor"},   int'(rsp_oor), oor);
        chk({tag, " hit"},   int'(rsp_hit), (slot >= 0) ? 1 : 0);
        chk({tag, " slot"},  int'(rsp_slot), (slot >= 0) ? slot : 0);
        chk({tag, " chan"},  int'(rsp_chan), (slot >= 0) ? slot / 4 : 0);
        chk({tag, " rank"},  int'(rsp_rank), (slot >= 0) ? slot % 4 : 0);
    endtask

    task automatic one_req(input string tag, input int unit, input longint off,
                           input int oor, input int slot);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 36'((longint'(unit) << GSH) + off);
        @(negedge clk);
        req_valid = 1'b0;
        check_result(tag, oor, slot);
        @(negedge clk);
        chk({tag, " R2 valid drops"}, int'(rsp_valid), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(rsp_valid), 0);
        chk("R1 hit in reset",   int'(rsp_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(rsp_valid), 0);
        chk("R1 oor after reset",   int'(rsp_oor), 0);
    endtask

    task automatic t_flat;
        // ch0 {4,8,8,12} rank2 empty; ch1 offsets {2,2,6,6}; tom 18
        set_cfg(4, 8, 8, 12, 2, 2, 6, 6, 18, 1'b0);
        chk("R6 not stacked", int'(layout_stacked), 0);
        one_req("R3 ch0 rank0 base", 0, 0, 0, 0);
        one_req("R4 last byte of rank0", 3, (64'd1 << GSH) - 1, 0, 0);
        one_req("R4 boundary to rank1", 4, 0, 0, 1);
        one_req("R7 empty rank2 skipped", 8, 0, 0, 3);
        one_req("R3 ch0 rank3", 11, 5, 0, 3);
        one_req("R5 ch1 rank0 above ch0", 12, 0, 0, 4);
        one_req("R11 ch1 rank2 slot", 15, 0, 0, 6);
        one_req("R5 ch1 rank2 top", 17, 0, 0, 6);
        one_req("R9 at tom", 18, 0, 1, -1);
        one_req("R9 max address", 1023, 0, 1, -1);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 36'(longint'(5) << GSH);
        @(negedge clk);
        check_result("R2 first of pair", 0, 1);
        req_addr  = 36'(longint'(13) << GSH);
        @(negedge clk);
        req_valid = 1'b0;
        check_result("R2 second of pair", 0, 4);
        @(negedge clk);
        chk("R2 pair valid drops", int'(rsp_valid), 0);
    endtask

    task automatic t_stacked;
        set_cfg(4, 8, 12, 16, 20, 24, 28, 32, 32, 1'b0);
        chk("R6 stacked detected", int'(layout_stacked), 1);
        one_req("R6 stacked ch0 rank1", 5, 0, 0, 1);
        one_req("R6 stacked ch1 rank0", 16, 0, 0, 4);
        one_req("R6 stacked ch1 rank3", 31, 0, 0, 7);
        one_req("R9 stacked tom", 32, 0, 1, -1);
    endtask

    task automatic t_single;
        set_cfg(4, 8, 12, 16, 20, 24, 28, 32, 32, 1'b1);
        chk("R10 single not stacked", int'(layout_stacked), 0);
        one_req("R10 single ch0 ok", 3, 0, 0, 0);
        one_req("R10 R12 single ch1 miss", 20, 0, 0, -1);
    endtask

    task automatic t_overlap;
        // stacked: ch1 rank1 window [2,10) overlaps ch0 rank0 [0,8)
        set_cfg(8, 8, 8, 8, 2, 10, 10, 10, 10, 1'b0);
        chk("R8 overlap stacked", int'(layout_stacked), 1);
        one_req("R8 lowest slot wins", 5, 0, 0, 0);
        one_req("R8 upper part to slot5", 9, 0, 0, 5);
    endtask

    task automatic t_oor_vs_match;
        // ch0 reaches 16 but tom is 10
        set_cfg(4, 8, 12, 16, 0, 0, 0, 0, 10, 1'b0);
        one_req("R9 oor beats rank match", 12, 0, 1, -1);
        one_req("R3 below tom still hits", 9, 0, 0, 2);
    endtask

    initial begin
        t_reset();
        t_flat();
        t_back_to_back();
        t_stacked();
        t_single();
        t_overlap();
        t_oor_vs_match();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule